// File: doc/BRIEF.md
# Cache Tag Store with Hit Compare

This block holds the tag directory of a secondary cache. Every entry keeps a tag field together with two status flags: one says the line is present, the other says it has been modified. The cache controller presents a set index and a tag. In compare mode the block raises `hit` when the stored tag equals the presented one and the entry is present. In read mode it returns the stored tag on the tag output bus. In write mode it stores a new tag and new flags at the next rising clock edge.

Reads and compares are combinational from the index and the tag. Writes take effect on the clock. An active-low clear line empties the whole directory at once. It resets every presence and modified flag and leaves the tag fields untouched. The tag bus of a shared-pin system is split into an input, an output and an output-valid strobe. All pins are level-sensitive control or status pins. A write is accepted in any cycle, so there is no valid/ready pairing and no back-pressure: the controller never waits.

The number of entries is 2^`IDX_W`. The default is 1024 entries, and 8K or 16K entries are reached by setting `IDX_W` to 13 or 14. `TAG_W` defaults to 14.

Top module: `tag_store_top`

## Requirements
- R1: With `clr_n`=1, `wr_n`=0 and `rd_en_n`=1, the rising clock edge stores `tag_in`, `present_in` and `modified_in` at entry `index`.
- R2: With `clr_n`=1, `wr_n`=1 and `rd_en_n`=0, `tag_out` equals the stored tag at `index`, `tag_out_vld`=1 and `hit`=0.
- R3: With `clr_n`=1, `wr_n`=1 and `rd_en_n`=1, `tag_out_vld`=0.
- R4: With `clr_n`=1, `wr_n`=1 and `rd_en_n`=1, `hit`=1 exactly when the stored tag at `index` equals `tag_in` and that entry's stored presence flag is 1.
- R5: Outside clear and outside a legal write, `modified_out` equals the stored modified flag at `index`.
- R6: During a legal write, `tag_out`=`tag_in`, `tag_out_vld`=1, `modified_out`=`modified_in` and `hit`=0.
- R7: With `clr_n`=1, `wr_n`=0 and `rd_en_n`=0, `wr_err`=1, `hit`=0 and nothing is stored. A later read returns the old tag.
- R8: While `clr_n`=0, `hit`, `modified_out`, `tag_out_vld` and `wr_err` are 0. After release, every entry compares as a miss and shows `modified_out`=0 until it is written again.
- R9: Clear leaves the tag fields unchanged, so a read after clear returns the tag written before it.
- R10: A write requested while `clr_n`=0 is ignored and is not performed after release.
- R11: Each of the 2^`IDX_W` entries is independent, from index 0 to the top index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| clr_n | input | 1 | Active-low directory clear, asynchronous, level-held |
| index | input | IDX_W | Set index |
| tag_in | input | TAG_W | Compare tag and write data |
| wr_n | input | 1 | Active-low write request |
| rd_en_n | input | 1 | Active-low tag output enable |
| present_in | input | 1 | Presence flag to write |
| modified_in | input | 1 | Modified flag to write |
| tag_out | output | TAG_W | Tag output bus (zero when not driven) |
| tag_out_vld | output | 1 | Tag output bus is driven |
| hit | output | 1 | Compare hit |
| modified_out | output | 1 | Modified flag of the addressed entry |
| wr_err | output | 1 | Illegal write: write with output enable low |

## Verification
Two pairs of functions can coincide. A write can be requested while the output enable is low, and a write can be requested while clear is held. The bench raises both conditions on purpose at a chosen index, with a tag that differs from the stored one. It judges the result in three ways: the error strobe and the quiet outputs in that cycle; a read of the same index after the event, which must return the old tag; and a compare sweep over all entries, which must report a miss with the modified flag clear wherever clear intervened.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;

  typedef enum logic [2:0] {
    OP_CLEAR = 3'd0,
    OP_WRITE = 3'd1,
    OP_BADWR = 3'd2,
    OP_READ  = 3'd3,
    OP_CMP   = 3'd4
  } tag_op_e;

endpackage

// File: rtl/tag_store_ctrl.sv
module tag_store_ctrl
  import tag_store_pkg::*;
(
  input  logic    clr_n,
  input  logic    wr_n,
  input  logic    rd_en_n,
  output tag_op_e op,
  output logic    we,
  output logic    err
);

  always_comb begin
    if (!clr_n) begin
      op = OP_CLEAR;
    end else if (!wr_n) begin
      op = rd_en_n ? OP_WRITE : OP_BADWR;
    end else begin
      op = rd_en_n ? OP_CMP : OP_READ;
    end
  end

  assign we  = (op == OP_WRITE);
  assign err = (op == OP_BADWR);

endmodule

// File: rtl/tag_store_status.sv
module tag_store_status #(
  parameter int IDX_W = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             we,
  input  logic             err,
  input  logic [IDX_W-1:0] index,
  input  logic             present_in,
  input  logic             modified_in,
  output logic             present_rd,
  output logic             modified_rd
);

  logic [DEPTH-1:0] present_q;
  logic [DEPTH-1:0] modified_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      present_q  <= '0;
      modified_q <= '0;
    end else if (we) begin
      present_q[index]  <= present_in;
      modified_q[index] <= modified_in;
    end
  end

  assign present_rd  = present_q[index];
  assign modified_rd = modified_q[index];

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
    !$past(we) |-> ($stable(present_q) && $stable(modified_q))) // R7
    else $error("flags changed without a write");

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!clr_n)
    err |-> !we) // R7
    else $error("illegal write enabled storage");

endmodule

// File: rtl/tag_store_array.sv
module tag_store_array #(
  parameter int IDX_W = 10,
  parameter int TAG_W = 14,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] index,
  input  logic [TAG_W-1:0] wdata,
  output logic [TAG_W-1:0] rdata
);

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[index] <= wdata;
    end
  end

  assign rdata = mem[index];

endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp #(
  parameter int TAG_W = 14
) (
  input  logic [TAG_W-1:0] a,
  input  logic [TAG_W-1:0] b,
  input  logic             present,
  output logic             equal_hit
);

  logic [TAG_W-1:0] bit_eq;

  for (genvar g = 0; g < TAG_W; g++) begin : g_bit
    assign bit_eq[g] = ~(a[g] ^ b[g]);
  end

  assign equal_hit = present & (&bit_eq);

endmodule

// File: rtl/tag_store_top.sv
module tag_store_top
  import tag_store_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int TAG_W = 14
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [IDX_W-1:0] index,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             wr_n,
  input  logic             rd_en_n,
  input  logic             present_in,
  input  logic             modified_in,
  output logic [TAG_W-1:0] tag_out,
  output logic             tag_out_vld,
  output logic             hit,
  output logic             modified_out,
  output logic             wr_err
);

  tag_op_e          op;
  logic             we;
  logic             err;
  logic [TAG_W-1:0] st_tag;
  logic             st_present;
  logic             st_modified;
  logic             cmp_hit;

  tag_store_ctrl u_ctrl (
    .clr_n   (clr_n),
    .wr_n    (wr_n),
    .rd_en_n (rd_en_n),
    .op      (op),
    .we      (we),
    .err     (err)
  );

  tag_store_status #(.IDX_W(IDX_W)) u_status (
    .clk         (clk),
    .clr_n       (clr_n),
    .we          (we),
    .err         (err),
    .index       (index),
    .present_in  (present_in),
    .modified_in (modified_in),
    .present_rd  (st_present),
    .modified_rd (st_modified)
  );

  tag_store_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk   (clk),
    .we    (we),
    .index (index),
    .wdata (tag_in),
    .rdata (st_tag)
  );

  tag_store_cmp #(.TAG_W(TAG_W)) u_cmp (
    .a         (st_tag),
    .b         (tag_in),
    .present   (st_present),
    .equal_hit (cmp_hit)
  );

  always_comb begin
    tag_out      = '0;
    tag_out_vld  = 1'b0;
    hit          = 1'b0;
    modified_out = 1'b0;
    unique case (op)
      OP_CLEAR: begin
      end
      OP_WRITE: begin
        tag_out      = tag_in;
        tag_out_vld  = 1'b1;
        modified_out = modified_in;
      end
      OP_BADWR: begin
        modified_out = st_modified;
      end
      OP_READ: begin
        tag_out      = st_tag;
        tag_out_vld  = 1'b1;
        modified_out = st_modified;
      end
      OP_CMP: begin
        hit          = cmp_hit;
        modified_out = st_modified;
      end
      default: begin
      end
    endcase
  end

  assign wr_err = err;

  AST_CLEAR_QUIET: assert property (@(posedge clk)
    !clr_n |-> (!hit && !modified_out && !tag_out_vld && !wr_err)) // R8
    else $error("outputs active during clear");

  AST_WRITE_NO_HIT: assert property (@(posedge clk) disable iff (!clr_n)
    !wr_n |-> !hit) // R6
    else $error("hit during write");

  AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(!wr_n && rd_en_n && present_in) && index == $past(index) &&
     tag_in == $past(tag_in) && wr_n && rd_en_n) |-> hit) // R4
    else $error("no hit after matching write");

  AST_WRITE_THEN_MOD: assert property (@(posedge clk) disable iff (!clr_n)
    ($past(!wr_n && rd_en_n) && index == $past(index) && wr_n) |->
      (modified_out == $past(modified_in))) // R5
    else $error("modified flag not kept");

endmodule

// File: tb/test_tag_store_top.sv
module test_tag_store_top;

  localparam int IDX_W = 4;
  localparam int TAG_W = 6;
  localparam int DEPTH = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             clr_n;
  logic [IDX_W-1:0] index;
  logic [TAG_W-1:0] tag_in;
  logic             wr_n, rd_en_n, present_in, modified_in;
  logic [TAG_W-1:0] tag_out;
  logic             tag_out_vld, hit, modified_out, wr_err;

  int n_checks = 0;
  int n_errors = 0;

  logic [TAG_W-1:0] m_tag [DEPTH];
  logic             m_pres [DEPTH];
  logic             m_mod  [DEPTH];

  always #2.5 clk = ~clk;

  tag_store_top #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tag_store_top (
    .clk(clk), .clr_n(clr_n), .index(index), .tag_in(tag_in),
    .wr_n(wr_n), .rd_en_n(rd_en_n), .present_in(present_in),
    .modified_in(modified_in), .tag_out(tag_out), .tag_out_vld(tag_out_vld),
    .hit(hit), .modified_out(modified_out), .wr_err(wr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [TAG_W-1:0] pat(input int i, input int k);
    return TAG_W'((i * 5 + 3 + k * 11) % (1 << TAG_W));
  endfunction

  task automatic drive(input logic c, input int idx, input logic [TAG_W-1:0] t,
                       input logic w, input logic oe, input logic p, input logic m);
    @(negedge clk);
    clr_n = c; index = IDX_W'(idx); tag_in = t; wr_n = w; rd_en_n = oe;
    present_in = p; modified_in = m;
    #1;
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < DEPTH; i++) begin
      m_tag[i] = pat(i, k);
      m_pres[i] = ((i + k) % 3) != 0;
      m_mod[i] = ((i + k) % 2) == 1;
      drive(1, i, m_tag[i], 0, 1, m_pres[i], m_mod[i]);
      chk("R6 pass tag", int'(tag_out), int'(m_tag[i]));
      chk("R6 vld", int'(tag_out_vld), 1);
      chk("R6 mod", int'(modified_out), int'(m_mod[i]));
      chk("R6 hit", int'(hit), 0);
      chk("R7 no err", int'(wr_err), 0);
    end
  endtask

  task automatic sweep_read();
    for (int i = 0; i < DEPTH; i++) begin
      drive(1, i, '0, 1, 0, 0, 0);
      chk("R2 tag", int'(tag_out), int'(m_tag[i]));
      chk("R2 vld", int'(tag_out_vld), 1);
      chk("R2 hit", int'(hit), 0);
      chk("R5 mod", int'(modified_out), int'(m_mod[i]));
    end
  endtask

  task automatic sweep_cmp();
    for (int i = 0; i < DEPTH; i++) begin
      drive(1, i, m_tag[i], 1, 1, 0, 0);
      chk("R4 hit same tag", int'(hit), int'(m_pres[i]));
      chk("R3 vld off", int'(tag_out_vld), 0);
      chk("R5 mod", int'(modified_out), int'(m_mod[i]));
      drive(1, i, m_tag[i] ^ TAG_W'(1 << (i % TAG_W)), 1, 1, 0, 0);
      chk("R4 miss other tag", int'(hit), 0);
    end
  endtask

  initial begin
    #500000;
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    clr_n = 0; index = '0; tag_in = '0; wr_n = 1; rd_en_n = 1;
    present_in = 0; modified_in = 0;
    repeat (3) @(posedge clk);
    drive(0, 0, '0, 1, 0, 0, 0);
    chk("R8 reset vld", int'(tag_out_vld), 0);
    chk("R8 reset hit", int'(hit), 0);
    chk("R8 reset mod", int'(modified_out), 0);

    // R1 R11: fill every entry, then read and compare each one
    fill(0);
    sweep_read();
    sweep_cmp();

    // R7: illegal write at index 2
    drive(1, 2, ~m_tag[2], 0, 0, 1, 1);
    chk("R7 err", int'(wr_err), 1);
    chk("R7 hit", int'(hit), 0);
    drive(1, 2, '0, 1, 0, 0, 0);
    chk("R7 old tag kept", int'(tag_out), int'(m_tag[2]));
    chk("R7 old mod kept", int'(modified_out), int'(m_mod[2]));

    // R10 R8: write requested during clear
    drive(0, 5, ~m_tag[5], 0, 1, 1, 1);
    chk("R8 clear vld", int'(tag_out_vld), 0);
    chk("R8 clear mod", int'(modified_out), 0);
    chk("R8 clear err", int'(wr_err), 0);
    drive(0, 5, ~m_tag[5], 0, 0, 1, 1);
    chk("R8 clear err oe", int'(wr_err), 0);
    for (int i = 0; i < DEPTH; i++) begin
      m_pres[i] = 0;
      m_mod[i] = 0;
    end
    // R9: tags survive clear, R10: index 5 unchanged
    sweep_read();
    chk("R10 idx5 tag", int'(m_tag[5]), int'(pat(5, 0)));
    sweep_cmp();

    // R1 R11: rewrite with a new pattern, edge indices included
    fill(1);
    sweep_cmp();
    drive(1, DEPTH - 1, '0, 1, 0, 0, 0);
    chk("R11 top entry", int'(tag_out), int'(pat(DEPTH - 1, 1)));
    drive(1, 0, '0, 1, 0, 0, 0);
    chk("R11 bottom entry", int'(tag_out), int'(pat(0, 1)));

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule